// File: doc/BRIEF.md
# Real-Time-Clock Bus Transaction Monitor

This block sits beside an I2C bus decoder and listens without driving anything. The decoder hands it one event per strobe: a start, a repeated start, a stop, an address phase in either direction, or a data byte in either direction. From these events the monitor rebuilds accesses to a small time-keeping register file at one fixed slave address. It follows the register pointer the bus master writes first. It then follows that pointer as it auto-increments through a burst of writes, or through a burst of reads after a repeated start.

Each register byte seen in a burst is turned from packed BCD into plain binary fields as soon as it arrives. The fields are seconds, minutes, hour, weekday, day of month, month and a four-digit year, plus flags for clock halt, 12-hour mode and PM. When the transaction's stop arrives, a one-cycle strobe marks the record as complete. A companion flag tells whether the burst was a write or a read. Bytes for the control register, or for pointer values beyond it, leave every field as it was.

Top module: `rtc_bus_monitor`

## Requirements
- R1: While `rst_n` is low at a clock edge, the monitor returns to idle and clears every field, flag, `rec_valid` and `rec_is_read` to zero.
- R2: In idle, every event other than a start is ignored. No field changes and no record strobe appears.
- R3: Events are presented with `ev_valid` high and a `ev_kind` code: 0 start, 1 repeated start, 2 stop, 3 address-write, 4 address-read, 5 data-write, 6 data-read. After a start and an address-write, the first data-write byte loads the register pointer. Each later data-write byte updates the register at the pointer, and the pointer then advances by one. A stop ends the transaction, and in the cycle after the stop edge `rec_valid` is high for one cycle with `rec_is_read` = 0.
- R4: A repeated start during the write burst, followed by an address-read, starts a read burst. Each data-read byte decodes into the register at the pointer, and the pointer then advances. On the stop, `rec_valid` pulses with `rec_is_read` = 1.
- R5: Register 0 holds seconds. Bit 7 drives `halt`, and bits 6..0 are BCD that becomes `sec`.
- R6: Register 2 holds the hour. With bit 6 set, the register is in 12-hour mode: `mode12` = 1, `pm` takes bit 5, and `hour` is the BCD value of bits 4..0. With bit 6 clear, `mode12` = 0, `pm` = 0, and `hour` is the BCD value of bits 5..0.
- R7: Register 6 is a full-byte BCD value, and `year` = 2000 plus that value.
- R8: Register 1 is minutes (BCD bits 6..0). Register 3 is weekday (bits 2..0). Register 4 is the day of month (BCD bits 5..0). Register 5 is the month (BCD bits 4..0). Each BCD value is converted as low nibble plus ten times the masked upper nibble.
- R9: An address event whose byte carries a 7-bit address in bits 6..0 other than 0x68 sends the monitor back to idle. The data bytes that follow change nothing.
- R10: Pointer value 7 (control) and pointer values above 7 update no field. Events that the current state does not expect leave the state and pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event strobe |
| ev_kind | input | 3 | Event code (see R3) |
| ev_byte | input | 8 | Address or data byte of the event |
| sec | output | 7 | Seconds, binary |
| min | output | 7 | Minutes, binary |
| hour | output | 6 | Hour, binary |
| wday | output | 3 | Day of week |
| mday | output | 6 | Day of month, binary |
| month | output | 5 | Month, binary |
| year | output | 12 | Four-digit year, binary |
| halt | output | 1 | Clock-halt flag |
| mode12 | output | 1 | 12-hour mode flag |
| pm | output | 1 | PM flag in 12-hour mode |
| rec_valid | output | 1 | One-cycle record-complete strobe |
| rec_is_read | output | 1 | Completed record was a read burst |

## Verification
A table of single-register write bursts drives every register with bytes whose masked bits are set. This separates correct masking from raw copying, and it includes BCD digits that need the times-ten step. Three hour bytes tell 24-hour, 12-hour AM and 12-hour PM apart. Multi-byte write and read bursts show that the pointer advances across registers and that the read flag follows the phase. Idle noise, a foreign slave address, a control-register pointer, an out-of-range pointer and a data-read inside a write burst show that ignored events leave the fields and the pointer alone.

// File: rtl/rtc_bus_monitor.sv
module rtc_bus_monitor #(
  parameter logic [6:0] SLAVE_ADDR = 7'h68,
  parameter int         YEAR_BASE  = 2000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ev_valid,
  input  logic [2:0]  ev_kind,
  input  logic [7:0]  ev_byte,
  output logic [6:0]  sec,
  output logic [6:0]  min,
  output logic [5:0]  hour,
  output logic [2:0]  wday,
  output logic [5:0]  mday,
  output logic [4:0]  month,
  output logic [11:0] year,
  output logic        halt,
  output logic        mode12,
  output logic        pm,
  output logic        rec_valid,
  output logic        rec_is_read
);
  localparam logic [2:0] EV_START = 3'd0, EV_RSTART = 3'd1, EV_STOP = 3'd2,
                         EV_AWR = 3'd3, EV_ARD = 3'd4, EV_DWR = 3'd5, EV_DRD = 3'd6;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_PTR, S_WR, S_RADDR, S_RD} state_t;

  state_t     state;
  logic [7:0] ptr;
  logic [7:0] masked;
  logic [7:0] bin;

  function automatic logic [7:0] bcd2bin(input logic [7:0] b);
    return {4'd0, b[3:0]} + ({4'd0, b[7:4]} << 3) + ({4'd0, b[7:4]} << 1);
  endfunction

  wire is_addr = (ev_kind == EV_AWR) || (ev_kind == EV_ARD);
  wire addr_ok = ev_byte[6:0] == SLAVE_ADDR;
  wire decode  = ev_valid && ((state == S_WR && ev_kind == EV_DWR) ||
                              (state == S_RD && ev_kind == EV_DRD));

  always_comb begin
    case (ptr[2:0])
      3'd0, 3'd1: masked = {1'b0, ev_byte[6:0]};
      3'd2:       masked = ev_byte[6] ? {3'd0, ev_byte[4:0]} : {2'd0, ev_byte[5:0]};
      3'd3:       masked = {5'd0, ev_byte[2:0]};
      3'd4:       masked = {2'd0, ev_byte[5:0]};
      3'd5:       masked = {3'd0, ev_byte[4:0]};
      default:    masked = ev_byte;
    endcase
    bin = bcd2bin(masked);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;  ptr <= '0;
      sec <= '0; min <= '0; hour <= '0; wday <= '0; mday <= '0; month <= '0; year <= '0;
      halt <= 1'b0; mode12 <= 1'b0; pm <= 1'b0;
      rec_valid <= 1'b0; rec_is_read <= 1'b0;
    end else begin
      rec_valid <= 1'b0;
      if (ev_valid) begin
        if (is_addr && !addr_ok && state != S_IDLE) state <= S_IDLE;
        else case (state)
          S_IDLE:  if (ev_kind == EV_START) state <= S_ADDR;
          S_ADDR:  if (ev_kind == EV_AWR) state <= S_PTR;
          S_PTR:   if (ev_kind == EV_DWR) begin ptr <= ev_byte; state <= S_WR; end
          S_WR: begin
            if (ev_kind == EV_RSTART) state <= S_RADDR;
            else if (ev_kind == EV_STOP) begin
              state <= S_IDLE; rec_valid <= 1'b1; rec_is_read <= 1'b0;
            end
          end
          S_RADDR: begin
            if (ev_kind == EV_ARD) state <= S_RD;
            else if (ev_kind == EV_STOP) begin
              state <= S_IDLE; rec_valid <= 1'b1; rec_is_read <= 1'b1;
            end
          end
          S_RD: if (ev_kind == EV_STOP) begin
            state <= S_IDLE; rec_valid <= 1'b1; rec_is_read <= 1'b1;
          end
          default: state <= S_IDLE;
        endcase
      end
      if (decode) begin
        ptr <= ptr + 8'd1;
        if (ptr < 8'd7) begin
          case (ptr[2:0])
            3'd0: begin sec <= bin[6:0]; halt <= ev_byte[7]; end
            3'd1: min <= bin[6:0];
            3'd2: begin hour <= bin[5:0]; mode12 <= ev_byte[6]; pm <= ev_byte[6] & ev_byte[5]; end
            3'd3: wday <= bin[2:0];
            3'd4: mday <= bin[5:0];
            3'd5: month <= bin[4:0];
            default: year <= 12'(YEAR_BASE) + {4'd0, bin};
          endcase
        end
      end
    end
  end

  // R3
  rec_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> $past(ev_valid && ev_kind == EV_STOP));

  // R3
  rec_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |=> !rec_valid);

  // R2
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !(ev_valid && ev_kind == EV_START)) |=> state == S_IDLE);

  // R10
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_valid |=> ($stable(state) && $stable(ptr) && $stable(sec) && $stable(year)));

  // R6
  pm_needs_mode12_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pm |-> mode12);
endmodule

// File: tb/rtc_bus_monitor_tb.sv
module rtc_bus_monitor_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_valid = 1'b0;
  logic [2:0] ev_kind = '0;
  logic [7:0] ev_byte = '0;
  logic [6:0] sec, min;
  logic [5:0] hour, mday;
  logic [2:0] wday;
  logic [4:0] month;
  logic [11:0] year;
  logic halt, mode12, pm, rec_valid, rec_is_read;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rtc_bus_monitor u_dut (.clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
    .ev_byte(ev_byte), .sec(sec), .min(min), .hour(hour), .wday(wday), .mday(mday),
    .month(month), .year(year), .halt(halt), .mode12(mode12), .pm(pm),
    .rec_valid(rec_valid), .rec_is_read(rec_is_read));

  // {ptr, byte, expected field, expected halt (ptr 0) or pm (ptr 2)}
  localparam logic [23:0] VEC [11] = '{
    {3'd0, 8'h59, 12'd59,   1'b0},
    {3'd0, 8'hA5, 12'd25,   1'b1},
    {3'd1, 8'hC7, 12'd47,   1'b0},
    {3'd2, 8'h23, 12'd23,   1'b0},
    {3'd2, 8'h72, 12'd12,   1'b1},
    {3'd2, 8'h49, 12'd9,    1'b0},
    {3'd3, 8'hFD, 12'd5,    1'b0},
    {3'd4, 8'hF1, 12'd31,   1'b0},
    {3'd5, 8'hF2, 12'd12,   1'b0},
    {3'd6, 8'h99, 12'd2099, 1'b0},
    {3'd6, 8'h00, 12'd2000, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] k, input logic [7:0] b);
    @(negedge clk); ev_valid = 1'b1; ev_kind = k; ev_byte = b;
    @(negedge clk); ev_valid = 1'b0;
  endtask

  function automatic int field(input logic [2:0] p);
    case (p)
      3'd0: return int'(sec);
      3'd1: return int'(min);
      3'd2: return int'(hour);
      3'd3: return int'(wday);
      3'd4: return int'(mday);
      3'd5: return int'(month);
      default: return int'(year);
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check("R1 sec", sec, 0); check("R1 year", year, 0);
    check("R1 flags", {halt, mode12, pm, rec_valid, rec_is_read}, 0);
    rst_n = 1'b1;

    // R5 R6 R7 R8 table of single-register writes
    for (int i = 0; i < 11; i++) begin
      send(0, 8'h00); send(3, 8'h68); send(5, {5'd0, VEC[i][23:21]});
      send(5, VEC[i][20:13]);
      send(2, 8'h00);
      check("R3 rec write", {rec_valid, rec_is_read}, 2);
      check("R5 R6 R7 R8 field", field(VEC[i][23:21]), int'(VEC[i][12:1]));
      if (VEC[i][23:21] == 3'd0) check("R5 halt", halt, VEC[i][0]);
      if (VEC[i][23:21] == 3'd2) begin
        check("R6 pm", pm, VEC[i][0]);
        check("R6 mode12", mode12, int'(VEC[i][19]));
      end
    end

    // R3 auto-increment write burst
    send(0, 0); send(3, 8'h68); send(5, 8'h00); send(5, 8'h30); send(5, 8'h45);
    check("R3 sec", sec, 30); check("R3 min", min, 45);
    send(2, 0);
    check("R3 rec", {rec_valid, rec_is_read}, 2);
    @(negedge clk); check("R3 pulse", rec_valid, 0);

    // R2 idle ignores non-start events
    send(5, 8'h11); send(6, 8'h11); send(3, 8'h68); send(5, 8'h22); send(2, 0);
    check("R2 no rec", rec_valid, 0); check("R2 sec", sec, 30); check("R2 min", min, 45);

    // R4 read burst after repeated start
    send(0, 0); send(3, 8'h68); send(5, 8'h04); send(1, 0); send(4, 8'h68);
    send(6, 8'h15); send(6, 8'h08); send(6, 8'h24);
    check("R4 mday", mday, 15); check("R4 month", month, 8); check("R4 year", year, 2024);
    send(2, 0);
    check("R4 rec read", {rec_valid, rec_is_read}, 3);

    // R9 foreign slave
    send(0, 0); send(3, 8'h50); send(5, 8'h00); send(5, 8'h33); send(2, 0);
    check("R9 sec", sec, 30); check("R9 no rec", rec_valid, 0);
    send(0, 0); send(3, 8'h68); send(5, 8'h00); send(1, 0); send(4, 8'h51);
    send(6, 8'h12); send(2, 0);
    check("R9 read sec", sec, 30); check("R9 read no rec", rec_valid, 0);

    // R10 control register, out-of-range pointer, unexpected event
    send(0, 0); send(3, 8'h68); send(5, 8'h06); send(5, 8'h55); send(5, 8'h77); send(5, 8'h12);
    send(2, 0);
    check("R10 year kept only reg6", year, 2055); check("R10 sec", sec, 30);
    send(0, 0); send(3, 8'h68); send(5, 8'h20); send(5, 8'h01); send(2, 0);
    check("R10 ptr>7 sec", sec, 30); check("R10 ptr>7 min", min, 45);
    send(0, 0); send(3, 8'h68); send(5, 8'h00); send(6, 8'h11); send(4, 8'h68);
    send(5, 8'h42);
    check("R10 unexpected ignored", sec, 42); check("R10 min", min, 45);
    send(2, 0);

    // R1 reset mid-transaction
    send(0, 0); send(3, 8'h68);
    @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    check("R1 reset sec", sec, 0); check("R1 reset year", year, 0);
    send(5, 8'h00); send(5, 8'h09);
    check("R1 back to idle", sec, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); tests++; fails++; $display("FAIL watchdog: actual timeout expected finish"); end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule